// File: doc/BRIEF.md
# SPI Serial Target with Register Port

This block is an 8-bit SPI target (slave) that a local processor reaches over a simple register bus. Software places the next outgoing byte in a write-only transmit buffer and collects each incoming byte from a read-only receive buffer. A status register reports buffer and transfer state, and a configuration register picks the interrupt source and can switch off the input synchronizer.

The serial pins are sampled in the system clock domain. By default each pin passes through a two-flop synchronizer. Edges of the serial clock are found by comparing the selected sample with the one from the previous cycle. Transfers use SPI mode 0 with the most significant bit first. The received byte is moved to the receive buffer after the eighth rising edge of the serial clock, and the transmit byte is then reloaded so that the next byte can follow without a gap.

A single interrupt line is driven from one of two sources. The first is the transmit-buffer-empty level, which is the default. The second is a one-cycle pulse when a transfer completes. In the second case the completion flag must be cleared by a status read before another pulse can occur.

Top module: `spi_sub_port`

## Requirements
- R1: After reset the status register (address 2) reads 0x01 (only transmit-empty set), the configuration register (address 3) and the receive buffer (address 1) read 0x00, irq is 1 and spiMisoOe is 0.
- R2: A write to address 0 loads the transmit buffer and clears transmit-empty (status bit 0). A read of address 0 returns 0x00 and leaves the buffer unchanged.
- R3: Address 1 returns the last accepted received byte. Any read or write of address 1 clears receive-full (status bit 1). A write there leaves the buffer contents unchanged.
- R4: While selected, spiMiso presents the transmit byte MSB first and is valid before each rising serial clock edge. spiMosi is captured on each rising edge.
- R5: On the eighth rising edge the received byte moves to the receive buffer, and receive-full, done (status bit 3) and transmit-empty are set. The transmit buffer is reloaded for a following byte within the same selection.
- R6: If a byte completes while receive-full is set, overrun (status bit 2) is set and the new byte is discarded.
- R7: A read of the status register clears done and overrun.
- R8: Configuration bit 1 selects the interrupt source. When it is 0, irq follows transmit-empty. When it is 1, irq pulses for one cycle when done goes from 0 to 1.
- R9: While done stays set, further completed bytes produce no irq pulse.
- R10: Configuration bit 0 set bypasses the synchronizer. The select reaches spiMisoOe one clock after spiSsN falls, instead of three clocks, and transfers work in both settings.
- R11: spiMisoOe is 0 whenever the sampled spiSsN is high and 1 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (side effects only) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr |
| spiSclk | input | 1 | Serial clock from the controller |
| spiMosi | input | 1 | Serial data in |
| spiSsN | input | 1 | Active-low target select |
| spiMiso | output | 1 | Serial data out |
| spiMisoOe | output | 1 | Output enable for spiMiso |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data width and two synchronizer stages. With two stages, the select-to-enable latency differs measurably between the bypassed path and the synchronized path. The 8-bit width keeps every byte pattern in the table, including all-ones, all-zeros and alternating bits, directly comparable with the serial stream. Serial clock half-periods of several system clocks leave both paths enough margin for back-to-back bytes, overrun and the interrupt hold-off to be reached.

// File: rtl/spi_sub_pkg.sv
package spi_sub_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_TX   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RX   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd3;

  localparam int ST_TXE  = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_DONE = 3;

  localparam int CFG_BYP  = 0;
  localparam int CFG_ISEL = 1;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic sclkRise;
    logic sclkFall;
    logic selStart;
    logic selActive;
  } dpEvent_t;
endpackage

// File: rtl/spi_sub_dp.sv
module spi_sub_dp
  import spi_sub_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bypass,
  input  logic              sclkPin,
  input  logic              mosiPin,
  input  logic              ssNPin,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] txData,
  output dpEvent_t          evt,
  output logic [DATA_W-1:0] rxWord,
  output logic              misoBit,
  output logic              misoOe
);
  // pin bundle order: {sclk, mosi, ssN}
  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b001;

  logic [PIN_N-1:0] pinRaw;
  logic [PIN_N-1:0] pinSel;
  logic [PIN_N-1:0] syncQ [SYNC_STAGES];

  assign pinRaw = {sclkPin, mosiPin, ssNPin};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= PIN_IDLE;
      else if (g == 0) syncQ[g] <= pinRaw;
      else syncQ[g] <= syncQ[(g > 0) ? g-1 : 0];
    end
  end

  assign pinSel = bypass ? pinRaw : syncQ[SYNC_STAGES-1];

  logic sclkNow, mosiNow, ssNNow;
  assign {sclkNow, mosiNow, ssNNow} = pinSel;

  logic sclkPrev, ssLive;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      ssLive   <= 1'b0;
    end else begin
      sclkPrev <= sclkNow;
      ssLive   <= !ssNNow;
    end
  end

  assign evt.selActive = ssLive;
  assign evt.selStart  = !ssNNow && !ssLive;
  assign evt.sclkRise  = ssLive && !ssNNow && sclkNow && !sclkPrev;
  assign evt.sclkFall  = ssLive && !ssNNow && !sclkNow && sclkPrev;

  logic [DATA_W-1:0] txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= '0;
    else if (strobe.load) txShift <= txData;
    else if (strobe.shift) txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  assign rxWord = {rxShift[DATA_W-2:0], mosiNow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (evt.selStart) rxShift <= '0;
    else if (strobe.sample) rxShift <= rxWord;
  end

  assign misoBit = txShift[DATA_W-1];
  assign misoOe  = ssLive;
endmodule

// File: rtl/spi_sub_ctrl.sv
module spi_sub_ctrl
  import spi_sub_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  dpEvent_t          evt,
  input  logic [DATA_W-1:0] rxWord,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] txData,
  output logic              cfgBypass,
  output logic              irq
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] txBuf, rxBuf;
  logic txEmpty, rxFull, ovrFlag, doneFlag, donePulse;
  logic cfgIntSel;
  logic byteDone;
  logic txWr, rxAcc, statRd, cfgWr;

  assign txWr   = busWrEn && busAddr == ADDR_TX;
  assign rxAcc  = (busWrEn || busRdEn) && busAddr == ADDR_RX;
  assign statRd = busRdEn && busAddr == ADDR_STAT;
  assign cfgWr  = busWrEn && busAddr == ADDR_CFG;

  assign byteDone      = evt.sclkRise && bitCnt == LAST_BIT;
  assign strobe.sample = evt.sclkRise;
  assign strobe.load   = evt.selStart || byteDone;
  assign strobe.shift  = evt.sclkFall && bitCnt != '0;
  assign txData        = txBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (!evt.selActive || evt.selStart) bitCnt <= '0;
    else if (evt.sclkRise) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf     <= '0;
      txEmpty   <= 1'b1;
      rxBuf     <= '0;
      rxFull    <= 1'b0;
      ovrFlag   <= 1'b0;
      doneFlag  <= 1'b0;
      donePulse <= 1'b0;
      cfgBypass <= 1'b0;
      cfgIntSel <= 1'b0;
    end else begin
      if (txWr) begin
        txBuf   <= busWrData;
        txEmpty <= 1'b0;
      end else if (byteDone) begin
        txEmpty <= 1'b1;
      end

      if (byteDone && !rxFull) begin
        rxBuf  <= rxWord;
        rxFull <= 1'b1;
      end else if (rxAcc) begin
        rxFull <= 1'b0;
      end

      if (byteDone && rxFull) ovrFlag <= 1'b1;
      else if (statRd) ovrFlag <= 1'b0;

      if (byteDone) doneFlag <= 1'b1;
      else if (statRd) doneFlag <= 1'b0;

      donePulse <= byteDone && !doneFlag;

      if (cfgWr) begin
        cfgBypass <= busWrData[CFG_BYP];
        cfgIntSel <= busWrData[CFG_ISEL];
      end
    end
  end

  assign irq = cfgIntSel ? donePulse : txEmpty;

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_TX:   busRdData = '0;
      ADDR_RX:   busRdData = rxBuf;
      ADDR_STAT: begin
        busRdData[ST_TXE]  = txEmpty;
        busRdData[ST_RXF]  = rxFull;
        busRdData[ST_OVR]  = ovrFlag;
        busRdData[ST_DONE] = doneFlag;
      end
      default: begin
        busRdData[CFG_BYP]  = cfgBypass;
        busRdData[CFG_ISEL] = cfgIntSel;
      end
    endcase
  end
endmodule

// File: rtl/spi_sub_port.sv
module spi_sub_port
  import spi_sub_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              spiSclk,
  input  logic              spiMosi,
  input  logic              spiSsN,
  output logic              spiMiso,
  output logic              spiMisoOe,
  output logic              irq
);
  dpEvent_t          evt;
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] rxWord, txData;
  logic              cfgBypass;

  spi_sub_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .evt(evt), .rxWord(rxWord), .strobe(strobe), .txData(txData),
    .cfgBypass(cfgBypass), .irq(irq)
  );

  spi_sub_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .bypass(cfgBypass),
    .sclkPin(spiSclk), .mosiPin(spiMosi), .ssNPin(spiSsN),
    .strobe(strobe), .txData(txData), .evt(evt), .rxWord(rxWord),
    .misoBit(spiMiso), .misoOe(spiMisoOe)
  );
endmodule

// File: rtl/spi_sub_chk.sv
module spi_sub_chk
  import spi_sub_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic              irq,
  input logic              intSel,
  input logic              doneFlag,
  input logic              ovrFlag,
  input logic              rxFull,
  input logic [DATA_W-1:0] rxBuf,
  input logic              byteDone
);
  // R8
  tx_write_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_TX && !intSel) |=> !irq);

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intSel && irq && !(busWrEn && busAddr == ADDR_CFG)) |=> !irq);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && intSel && !(busWrEn && busAddr == ADDR_CFG)) |=> !irq);

  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && rxFull) |=> (ovrFlag && $stable(rxBuf)));

  // R3
  rx_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_RX && !byteDone) |=> ($stable(rxBuf) && !rxFull));

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_STAT && !byteDone) |=> (!doneFlag && !ovrFlag));
endmodule

bind spi_sub_port spi_sub_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .irq(irq),
  .intSel(uCtrl.cfgIntSel), .doneFlag(uCtrl.doneFlag),
  .ovrFlag(uCtrl.ovrFlag), .rxFull(uCtrl.rxFull),
  .rxBuf(uCtrl.rxBuf), .byteDone(uCtrl.byteDone)
);

// File: tb/spi_sub_port_test.sv
module spi_sub_port_test;
  import spi_sub_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       spiSclk = 1'b0, spiMosi = 1'b0, spiSsN = 1'b1;
  logic       spiMiso, spiMisoOe, irq;

  int nChecks = 0;
  int nFails  = 0;
  int nPulses = 0;
  logic irqPrev = 1'b0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  spi_sub_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiSsN(spiSsN),
    .spiMiso(spiMiso), .spiMisoOe(spiMisoOe), .irq(irq)
  );

  always @(posedge clk) begin
    irqPrev <= irq;
    if (irq && !irqPrev) nPulses <= nPulses + 1;
  end

  // {tx byte, mosi byte}
  localparam logic [15:0] VEC [5] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h817E, 16'h5AC3};

  task automatic checkEq(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic spiXfer(input logic [7:0] mosiByte, output logic [7:0] misoByte,
                         input bit deselect);
    if (spiSsN) begin
      spiSsN = 1'b0;
      repeat (8) @(negedge clk);
    end
    for (int i = 7; i >= 0; i--) begin
      spiMosi = mosiByte[i];
      repeat (4) @(negedge clk);
      misoByte[i] = spiMiso;
      spiSclk = 1'b1;
      repeat (8) @(negedge clk);
      spiSclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    if (deselect) begin
      spiSsN = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, mi;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    busRead(ADDR_STAT, rd); checkEq("R1 status", rd, 8'h01);
    busRead(ADDR_CFG, rd);  checkEq("R1 config", rd, 8'h00);
    busRead(ADDR_RX, rd);   checkEq("R1 rx", rd, 8'h00);
    checkEq("R1 irq", {7'd0, irq}, 8'h01);
    checkEq("R1 oe", {7'd0, spiMisoOe}, 8'h00);

    // R4 R5 table of byte patterns
    foreach (VEC[k]) begin
      busWrite(ADDR_TX, VEC[k][15:8]);
      busRead(ADDR_STAT, rd); checkEq("R2 txEmpty cleared", rd, 8'h00);
      spiXfer(VEC[k][7:0], mi, 1'b1);
      checkEq("R4 miso byte", mi, VEC[k][15:8]);
      busRead(ADDR_STAT, rd); checkEq("R5 status after byte", rd, 8'h0B);
      busRead(ADDR_RX, rd);   checkEq("R4 rx byte", rd, VEC[k][7:0]);
      busRead(ADDR_STAT, rd); checkEq("R7 R3 status cleared", rd, 8'h01);
    end

    // R11 deselected output enable
    checkEq("R11 oe idle", {7'd0, spiMisoOe}, 8'h00);

    // R2 read of transmit address returns zero, buffer kept
    busWrite(ADDR_TX, 8'h77);
    busRead(ADDR_TX, rd); checkEq("R2 tx read zero", rd, 8'h00);
    checkEq("R8 irq low after tx write", {7'd0, irq}, 8'h00);
    spiXfer(8'h12, mi, 1'b0);
    checkEq("R11 oe selected", {7'd0, spiMisoOe}, 8'h01);
    checkEq("R2 tx kept", mi, 8'h77);
    checkEq("R8 irq follows txEmpty", {7'd0, irq}, 8'h01);

    // R5 back-to-back byte reuses reloaded buffer
    busRead(ADDR_RX, rd); checkEq("R5 first of pair", rd, 8'h12);
    spiXfer(8'h34, mi, 1'b1);
    checkEq("R5 reload miso", mi, 8'h77);
    busRead(ADDR_RX, rd); checkEq("R5 second of pair", rd, 8'h34);

    // R3 write to receive address ignored, clears full
    busRead(ADDR_STAT, rd);
    spiXfer(8'h5E, mi, 1'b1);
    busWrite(ADDR_RX, 8'h99);
    busRead(ADDR_STAT, rd); checkEq("R3 write clears full", rd & 8'h02, 8'h00);
    busRead(ADDR_RX, rd);   checkEq("R3 write ignored", rd, 8'h5E);

    // R6 overrun
    busRead(ADDR_STAT, rd);
    spiXfer(8'h11, mi, 1'b1);
    spiXfer(8'h22, mi, 1'b1);
    busRead(ADDR_STAT, rd); checkEq("R6 overrun status", rd, 8'h0F);
    busRead(ADDR_RX, rd);   checkEq("R6 byte discarded", rd, 8'h11);
    busRead(ADDR_STAT, rd); checkEq("R7 overrun cleared", rd, 8'h01);

    // R8 R9 completion interrupt
    busWrite(ADDR_CFG, 8'h02);
    repeat (3) @(negedge clk);
    nPulses = 0;
    spiXfer(8'hA1, mi, 1'b1);
    checkEq("R8 one pulse", nPulses[7:0], 8'd1);
    busRead(ADDR_RX, rd);
    spiXfer(8'hA2, mi, 1'b1);
    checkEq("R9 no pulse while done", nPulses[7:0], 8'd1);
    busRead(ADDR_STAT, rd);
    busRead(ADDR_RX, rd);
    spiXfer(8'hA3, mi, 1'b1);
    checkEq("R9 pulse after status read", nPulses[7:0], 8'd2);
    busRead(ADDR_STAT, rd);
    busRead(ADDR_RX, rd);

    // R10 bypass latency and transfer
    busWrite(ADDR_CFG, 8'h01);
    busRead(ADDR_CFG, rd); checkEq("R10 config readback", rd, 8'h01);
    spiSsN = 1'b0;
    @(negedge clk);
    checkEq("R10 bypass one clock", {7'd0, spiMisoOe}, 8'h01);
    spiSsN = 1'b1;
    repeat (4) @(negedge clk);
    busWrite(ADDR_TX, 8'hC6);
    spiXfer(8'h6C, mi, 1'b1);
    checkEq("R10 bypass miso", mi, 8'hC6);
    busRead(ADDR_RX, rd); checkEq("R10 bypass rx", rd, 8'h6C);
    busWrite(ADDR_CFG, 8'h00);
    repeat (4) @(negedge clk);
    spiSsN = 1'b0;
    @(negedge clk);
    checkEq("R10 sync not yet", {7'd0, spiMisoOe}, 8'h00);
    repeat (2) @(negedge clk);
    checkEq("R10 sync three clocks", {7'd0, spiMisoOe}, 8'h01);
    spiSsN = 1'b1;
    repeat (5) @(negedge clk);
    checkEq("R11 oe after deselect", {7'd0, spiMisoOe}, 8'h00);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule